// File: doc/BRIEF.md
# Synchronous FIFO with Strap-Selected Write Qualifier or Threshold Load

A single-clock first-in first-out buffer for 9-bit words. Its capacity is a power of two set by a parameter; the target build holds 8192 words. Writes are qualified by an active-low enable and a second pin whose meaning is fixed by the level it holds while reset is asserted. If that pin is high during reset, it later acts as a second, active-high write enable. If it is low during reset, it later acts as an active-low strobe that sends the data input into the two programmable threshold registers instead of the storage. Reads need two active-low read enables, both asserted.

Four active-low status flags report the fill level: empty, almost-empty, almost-full and full. The almost thresholds come from the two programmable distances, and each distance defaults to 7 after reset. The read data register feeds the output bus. The output buffer is represented by a drive indication that follows an active-low output enable.

Top module: `sfifo_strap`

## Requirements
- R1: Words leave in the order they were accepted, and the buffer holds up to DEPTH = 2^ADDR_W words of 9 bits.
- R2: A word is stored only on an edge where `wr_en1_n` is 0 and `wr2_ld` is 1. A word is read only on an edge where both `rd_en1_n` and `rd_en2_n` are 0. With only one read enable low, the level and `dout` do not change.
- R3: The level of `wr2_ld` on the last reset edge fixes its role until the next reset: 1 selects second write enable, 0 selects threshold load strobe.
- R4: All flags are active low. `empty_n` is 0 exactly when the level is 0. `full_n` is 0 exactly when the level is DEPTH. `aempty_n` is 0 when level <= empty distance. `afull_n` is 0 when level >= DEPTH minus full distance.
- R5: After reset: `empty_n` = 0, `aempty_n` = 0, `full_n` = 1, `afull_n` = 1, `dout` = 0, both distances = 7, and the load sequence starts at its first slot.
- R6: A write while full and a read while empty are ignored: the level, the stored words and `dout` are unchanged.
- R7: In load role, an edge with `wr_en1_n` = 0 and `wr2_ld` = 0 stores `din` into the distances instead of the buffer. Successive loads go in a four-step cycle that wraps: empty-distance bits 8:0, empty-distance bits ADDR_W-1:9 (taken from `din` starting at bit 0), full-distance bits 8:0, full-distance upper bits. In this role, `wr2_ld` = 1 with `wr_en1_n` = 0 is a normal write.
- R8: `dout` takes the head word on the edge that performs a read and holds its value on every other edge.
- R9: A read and a write performed on the same edge leave the level unchanged.
- R10: `dout_drive` is 1 while `oe_n` is 0 and 0 while `oe_n` is 1, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for reads and writes |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 9 | Write data or threshold load data |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr2_ld | input | 1 | Strap-selected second write enable or load strobe |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Read data register |
| dout_drive | output | 1 | High when the data bus is driven |
| empty_n | output | 1 | Empty flag, active low |
| aempty_n | output | 1 | Almost-empty flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |
| full_n | output | 1 | Full flag, active low |

## Verification
The level counter, the distance registers and the read data register each change on the clock edge that samples the request. The flags are combinational from these registers, so all four flags and `dout` are due on the same edge as the stimulus, and `dout_drive` is due with no edge at all. The bench applies each stimulus 1 ns after a rising edge and compares 1 ns after the next rising edge, against a level, queue and distance model it updates for that edge. It sweeps the level over every value from 0 to DEPTH and back on a 1024-word build, in both roles, so each flag boundary is crossed in both directions.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int WORD_W  = 9;
    localparam int DEF_GAP = 7;

    typedef logic [WORD_W-1:0] word_t;

    // Order of the threshold load cycle; the sequence is behaviour.
    typedef enum logic [1:0] {
        SLOT_E_LO = 2'd0,
        SLOT_E_HI = 2'd1,
        SLOT_F_LO = 2'd2,
        SLOT_F_HI = 2'd3
    } ld_slot_e;

    // Internal flags, active high.
    typedef struct packed {
        logic empty;
        logic aempty;
        logic afull;
        logic full;
    } flags_t;

    typedef struct packed {
        logic wr;
        logic rd;
    } req_t;

    function automatic ld_slot_e slot_next(input ld_slot_e s);
        return ld_slot_e'(s + 2'd1);
    endfunction

    function automatic int lo_width(input int aw);
        return (aw < WORD_W) ? aw : WORD_W;
    endfunction

endpackage

// File: rtl/sfifo_gap.sv
module sfifo_gap
    import sfifo_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  word_t             din,
    input  logic              wr_en1_n,
    input  logic              wr2_ld,
    output logic              ld_role,
    output logic              ld_go,
    output logic [ADDR_W-1:0] e_gap,
    output logic [ADDR_W-1:0] f_gap
);

    localparam int LO_W = lo_width(ADDR_W);
    localparam int HI_W = ADDR_W - LO_W;

    ld_slot_e          slot;
    logic [ADDR_W-1:0] e_lo_nx, e_hi_nx, f_lo_nx, f_hi_nx;

    // Role strap: sampled on every reset edge, frozen afterwards.
    always_ff @(posedge clk) begin
        if (rst) ld_role <= ~wr2_ld;
    end

    assign ld_go = ld_role & ~wr_en1_n & ~wr2_ld;

    generate
        if (HI_W > 0) begin : g_split
            assign e_lo_nx = {e_gap[ADDR_W-1:LO_W], din[LO_W-1:0]};
            assign e_hi_nx = {din[HI_W-1:0], e_gap[LO_W-1:0]};
            assign f_lo_nx = {f_gap[ADDR_W-1:LO_W], din[LO_W-1:0]};
            assign f_hi_nx = {din[HI_W-1:0], f_gap[LO_W-1:0]};
        end else begin : g_narrow
            assign e_lo_nx = din[ADDR_W-1:0];
            assign e_hi_nx = e_gap;
            assign f_lo_nx = din[ADDR_W-1:0];
            assign f_hi_nx = f_gap;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            e_gap <= ADDR_W'(DEF_GAP);
            f_gap <= ADDR_W'(DEF_GAP);
            slot  <= SLOT_E_LO;
        end else if (ld_go) begin
            unique case (slot)
                SLOT_E_LO: e_gap <= e_lo_nx;
                SLOT_E_HI: e_gap <= e_hi_nx;
                SLOT_F_LO: f_gap <= f_lo_nx;
                SLOT_F_HI: f_gap <= f_hi_nx;
                default:   e_gap <= e_gap;
            endcase
            slot <= slot_next(slot);
        end
    end

    // R7
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_go |=> ($stable(e_gap) && $stable(f_gap)));

    // R3
    role_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(ld_role));

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  req_t              req,
    output logic              wr_go,
    output logic              rd_go,
    output logic [ADDR_W-1:0] wptr,
    output logic [ADDR_W-1:0] rptr,
    output logic [ADDR_W:0]   level
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LVL_W = ADDR_W + 1;

    logic at_full, at_empty;

    assign at_full  = (level == LVL_W'(DEPTH));
    assign at_empty = (level == '0);
    assign wr_go    = req.wr & ~at_full;
    assign rd_go    = req.rd & ~at_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (wr_go) wptr <= wptr + 1'b1;
            if (rd_go) rptr <= rptr + 1'b1;
            unique case ({wr_go, rd_go})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr && !req.rd && level == LVL_W'(DEPTH)) |=> ($stable(level) && $stable(wptr)));

    // R6
    udf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req.rd && !req.wr && level == '0) |=> ($stable(level) && $stable(rptr)));

    // R9
    rw_level_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_go && rd_go) |=> $stable(level));

endmodule

// File: rtl/sfifo_mem.sv
module sfifo_mem
    import sfifo_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] wptr,
    input  word_t             din,
    input  logic              rd_go,
    input  logic [ADDR_W-1:0] rptr,
    output word_t             q
);

    localparam int DEPTH = 1 << ADDR_W;

    word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_go) store[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (rd_go) q <= store[rptr];
    end

    // R8
    q_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(q));

endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags
    import sfifo_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W:0]   level,
    input  logic [ADDR_W-1:0] e_gap,
    input  logic [ADDR_W-1:0] f_gap,
    output flags_t            flg
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LVL_W = ADDR_W + 1;

    logic [ADDR_W:0] af_mark;

    assign af_mark    = LVL_W'(DEPTH) - {1'b0, f_gap};
    assign flg.empty  = (level == '0);
    assign flg.full   = (level == LVL_W'(DEPTH));
    assign flg.aempty = (level <= {1'b0, e_gap});
    assign flg.afull  = (level >= af_mark);

    // R4
    empty_in_ae_chk: assert property (@(posedge clk) disable iff (rst)
        flg.empty |-> (flg.aempty && !flg.afull));

    // R4
    full_in_af_chk: assert property (@(posedge clk) disable iff (rst)
        flg.full |-> (flg.afull && !flg.empty));

endmodule

// File: rtl/sfifo_strap.sv
module sfifo_strap
    import sfifo_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [8:0] din,
    input  logic       wr_en1_n,
    input  logic       wr2_ld,
    input  logic       rd_en1_n,
    input  logic       rd_en2_n,
    input  logic       oe_n,
    output logic [8:0] dout,
    output logic       dout_drive,
    output logic       empty_n,
    output logic       aempty_n,
    output logic       afull_n,
    output logic       full_n
);

    req_t              req;
    logic              ld_role, ld_go, wr_go, rd_go;
    logic [ADDR_W-1:0] e_gap, f_gap, wptr, rptr;
    logic [ADDR_W:0]   level;
    flags_t            flg;
    word_t             q;

    // Both roles need wr2_ld high for a buffer write.
    assign req.wr = ~wr_en1_n & wr2_ld;
    assign req.rd = ~rd_en1_n & ~rd_en2_n;

    sfifo_gap #(.ADDR_W(ADDR_W)) u_gap (
        .clk(clk), .rst(rst), .din(din), .wr_en1_n(wr_en1_n), .wr2_ld(wr2_ld),
        .ld_role(ld_role), .ld_go(ld_go), .e_gap(e_gap), .f_gap(f_gap)
    );

    sfifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .req(req), .wr_go(wr_go), .rd_go(rd_go),
        .wptr(wptr), .rptr(rptr), .level(level)
    );

    sfifo_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst(rst), .wr_go(wr_go), .wptr(wptr), .din(din),
        .rd_go(rd_go), .rptr(rptr), .q(q)
    );

    sfifo_flags #(.ADDR_W(ADDR_W)) u_flags (
        .clk(clk), .rst(rst), .level(level), .e_gap(e_gap), .f_gap(f_gap), .flg(flg)
    );

    assign dout       = q;
    assign dout_drive = ~oe_n;
    assign empty_n    = ~flg.empty;
    assign aempty_n   = ~flg.aempty;
    assign afull_n    = ~flg.afull;
    assign full_n     = ~flg.full;

    // R7
    ld_no_store_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_go && !req.rd) |=> $stable(level));

    // R5
    reset_flags_chk: assert property (@(posedge clk)
        rst |=> (!empty_n && !aempty_n && full_n && afull_n && dout == '0));

    // R3
    role_mux_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_role) |-> !ld_go);

endmodule

// File: tb/tb_sfifo_strap.sv
module tb_sfifo_strap;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 10;
    localparam int DEPTH      = 1 << AW;

    logic       clk = 1'b0;
    logic       rst;
    logic [8:0] din;
    logic       wr_en1_n, wr2_ld, rd_en1_n, rd_en2_n, oe_n;
    logic [8:0] dout;
    logic       dout_drive, empty_n, aempty_n, afull_n, full_n;

    sfifo_strap #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .din(din), .wr_en1_n(wr_en1_n), .wr2_ld(wr2_ld),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .oe_n(oe_n), .dout(dout),
        .dout_drive(dout_drive), .empty_n(empty_n), .aempty_n(aempty_n),
        .afull_n(afull_n), .full_n(full_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int m_mem [DEPTH];
    int head, tail, cnt, egap, fgap, ldi, exp_q;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_flags(input string tag);
        check({tag, " R4 empty_n"},  int'(empty_n),  int'(cnt != 0));
        check({tag, " R4 full_n"},   int'(full_n),   int'(cnt != DEPTH));
        check({tag, " R4 aempty_n"}, int'(aempty_n), int'(!(cnt <= egap)));
        check({tag, " R4 afull_n"},  int'(afull_n),  int'(!(cnt >= DEPTH - fgap)));
        check({tag, " R8 dout"},     int'(dout),     exp_q);
    endtask

    function automatic int pat(input int i);
        return (i * 37 + 5) & 9'h1ff;
    endfunction

    task automatic idle_inputs();
        wr_en1_n = 1'b1; wr2_ld = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1; din = '0;
    endtask

    task automatic apply_reset(input logic strap);
        rst = 1'b1; wr_en1_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1; wr2_ld = strap;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0; wr2_ld = 1'b1;
        head = 0; tail = 0; cnt = 0; egap = 7; fgap = 7; ldi = 0; exp_q = 0;
    endtask

    task automatic op(input bit w, input bit r, input int d);
        int pre;
        wr_en1_n = !w; rd_en1_n = !r; rd_en2_n = !r; din = d[8:0];
        @(posedge clk);
        #1;
        pre = cnt;
        if (r && pre > 0) begin
            exp_q = m_mem[head]; head = (head + 1) % DEPTH; cnt--;
        end
        if (w && pre < DEPTH) begin
            m_mem[tail] = d; tail = (tail + 1) % DEPTH; cnt++;
        end
        idle_inputs();
    endtask

    task automatic ld(input int d);
        wr2_ld = 1'b0; wr_en1_n = 1'b0; din = d[8:0];
        @(posedge clk);
        #1;
        case (ldi)
            0: egap = (egap & 'h200) | d;
            1: egap = (egap & 'h1ff) | ((d & 1) << 9);
            2: fgap = (fgap & 'h200) | d;
            default: fgap = (fgap & 'h1ff) | ((d & 1) << 9);
        endcase
        ldi = (ldi + 1) % 4;
        idle_inputs();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        idle_inputs();
        oe_n = 1'b0;
        rst  = 1'b1;

        // R5 / R3: reset with strap high, second write enable role
        apply_reset(1'b1);
        check_flags("R5 reset");
        check("R10 drive on", int'(dout_drive), 1);
        oe_n = 1'b1; #1;
        check("R10 drive off", int'(dout_drive), 0);
        oe_n = 1'b0; #1;
        check("R10 drive back", int'(dout_drive), 1);

        // R1 / R4: fill sweep over every level
        for (int i = 0; i < DEPTH; i++) begin
            op(1, 0, pat(i));
            check_flags("R1 fill");
        end
        // R6: write while full is ignored
        op(1, 0, 9'h0aa);
        check_flags("R6 overflow");
        // R6: full with read and write: only read happens
        op(1, 1, 9'h0bb);
        check_flags("R6 full rw");
        check("R8 head word", int'(dout), pat(0));
        // R1: drain sweep, order check
        while (cnt > 0) begin
            op(0, 1, 0);
            check_flags("R1 drain");
        end
        // R6: read while empty is ignored
        op(0, 1, 0);
        check_flags("R6 underflow");
        // R8: idle keeps dout
        op(0, 0, 0);
        check_flags("R8 idle");

        // R2 / R3: wr2_ld low in enable role blocks the write
        wr2_ld = 1'b0; wr_en1_n = 1'b0; din = 9'h1c3;
        @(posedge clk); #1;
        idle_inputs();
        check_flags("R2 R3 second enable low");
        op(1, 0, 9'h111);
        op(1, 0, 9'h122);
        check_flags("R2 two words");
        // R2: single read enable does nothing
        rd_en1_n = 1'b0;
        @(posedge clk); #1;
        idle_inputs();
        check_flags("R2 rd_en1 only");
        rd_en2_n = 1'b0;
        @(posedge clk); #1;
        idle_inputs();
        check_flags("R2 rd_en2 only");

        // R9: simultaneous read and write keeps the level
        for (int i = 0; i < 6; i++) begin
            op(1, 1, pat(100 + i));
            check_flags("R9 rw");
        end
        while (cnt > 0) op(0, 1, 0);
        check_flags("R9 drained");
        // R6 / R9: read and write on empty: write only
        op(1, 1, 9'h055);
        check_flags("R9 empty rw");
        op(0, 1, 0);
        check_flags("R9 empty rw read");

        // R3 / R7: reset with strap low, load role
        apply_reset(1'b0);
        check_flags("R5 reset load role");
        ld(9'h005);
        check_flags("R7 load e lo");
        ld(9'h001);
        check_flags("R7 load e hi");
        ld(9'h003);
        ld(9'h000);
        check_flags("R7 load f");
        check("R7 gaps e", egap, 517);
        // R7: writes with wr2_ld high store normally; sweep thresholds
        for (int i = 0; i < DEPTH; i++) begin
            op(1, 0, pat(i + 7));
            check_flags("R7 fill");
        end
        // R7: fifth load wraps to empty low bits
        ld(9'h010);
        check_flags("R7 wrap");
        check("R7 wrap gap", egap, 528);
        while (cnt > 0) begin
            op(0, 1, 0);
            check_flags("R7 drain");
        end

        summary();
        $finish;
    end

endmodule